// File: doc/BRIEF.md
# Pointer-Register Load/Store Address Generator

This block sits between instruction decode and the data memory port of a small 8-bit core. Each cycle it may take one 16-bit opcode together with the current contents of the three pointer register pairs. If the opcode is an indirect load or store, the block produces the following one clock later:

- the data memory address;
- the direction of the access;
- the data register it uses;
- which pointer it used;
- the new pointer value, when the addressing mode changes the pointer.

The pointer pairs are X (r27:r26), Y (r29:r28) and Z (r31:r30). There are four addressing modes:

- plain;
- post-increment;
- pre-decrement;
- a 6-bit unsigned displacement added to Y or Z.

The bits of the displacement are spread across the opcode. The block reassembles them.

The block also compares the computed address with a memory size input. An address at or above that size raises an out-of-bounds flag. In that case the access strobe and the pointer write-back are both suppressed, so the register file and the memory are left alone. The register file and the memory are outside this block.

Top module: `ptr_ldst_agen`

## Requirements
- R1: Outputs are registered with one cycle of latency. If `in_valid_i` was low in a cycle, or the opcode matched neither form, then `acc_o`, `oob_o` and `wb_en_o` are 0 in the following cycle.
- R2: Indirect form matching:
  - The indirect form matches when opcode bits 15:10 equal 100100.
  - Bit 9 is 1 for a store and 0 for a load.
  - Bits 8:4 are the data register index.
  - Bits 3:2 pick the pointer: 11 is X, 10 is Y, 00 is Z.
  - `ptr_sel_o` reports the pointer as 0 for X, 1 for Y and 2 for Z.
- R3: Indirect form modes and rejected codes:
  - Bits 1:0 pick the mode: 00 is plain, 01 is post-increment, 10 is pre-decrement.
  - Mode 11 is not recognised.
  - Pointer code 01 is not recognised.
  - Plain mode with Y or Z is not recognised.
- R4: Plain mode uses the pointer value as the address and never asserts `wb_en_o`.
- R5: Post-increment uses the old pointer value as the address. It writes back pointer+1, modulo 2^16.
- R6: Pre-decrement computes pointer-1, modulo 2^16. That value is both the address and the write-back value.
- R7: Displacement form:
  - It matches when (bits 15:12 AND 1101) equals 1000.
  - Bit 9 selects store and bits 8:4 give the register.
  - Bit 3 selects Y (1) or Z (0).
  - The displacement is {bit13, bits11:10, bits2:0}, taken as an unsigned value.
  - The address is pointer+displacement, modulo 2^16.
  - There is never a write-back.
- R8: When a recognised access has an address greater than or equal to `mem_size_i`, `oob_o` is 1 and both `acc_o` and `wb_en_o` are 0. Otherwise `oob_o` is 0.
- R9: A synchronous active-high reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid_i | input | 1 | Opcode and pointers are valid this cycle |
| insn_i | input | 16 | Opcode word |
| ptr_x_i | input | AW | Current X pointer pair |
| ptr_y_i | input | AW | Current Y pointer pair |
| ptr_z_i | input | AW | Current Z pointer pair |
| mem_size_i | input | AW+1 | Number of bytes of data memory |
| acc_o | output | 1 | In-bounds access to perform |
| oob_o | output | 1 | Recognised access was out of bounds |
| store_o | output | 1 | 1 for store, 0 for load |
| reg_idx_o | output | 5 | Data register index |
| ptr_sel_o | output | 2 | Pointer used: 0 X, 1 Y, 2 Z |
| addr_o | output | AW | Data memory address |
| wb_en_o | output | 1 | Write the pointer back |
| wb_ptr_o | output | AW | New pointer value |

## Verification
The assertions check several invariants on every cycle:
- an idle input cycle never produces a strobe;
- the access and error flags are never high together;
- a write-back only comes with an in-bounds access;
- the write-back value is always the address itself or the address plus one;
- an accepted address always lies below the sampled memory size.

Some behaviours need directed scenarios with known expected values:
- the exact reassembly of the scattered displacement bits;
- the pointer codes and modes that are rejected;
- the wrap of pre-decrement from 0 to FFFF;
- the boundary where the address equals the memory size.

The bench model checks these on every clock, for directed and random opcodes.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
  localparam int INSN_W    = 16;
  localparam int REG_IDX_W = 5;
  localparam int DISP_W    = 6;

  typedef enum logic [1:0] {
    PSEL_X = 2'd0,
    PSEL_Y = 2'd1,
    PSEL_Z = 2'd2
  } psel_e;

  typedef enum logic [1:0] {
    AM_PLAIN   = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_DISP    = 2'd3
  } amode_e;

  typedef struct packed {
    logic                 hit;
    logic                 store;
    logic [REG_IDX_W-1:0] reg_idx;
    psel_e                psel;
    amode_e               mode;
    logic [DISP_W-1:0]    disp;
  } lsag_dec_t;
endpackage

// File: rtl/lsag_decode.sv
module lsag_decode
  import lsag_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output lsag_dec_t         dec
);
  localparam logic [5:0] IND_PREFIX  = 6'b100100;
  localparam logic [3:0] DISP_MASK   = 4'b1101;
  localparam logic [3:0] DISP_PREFIX = 4'b1000;

  logic ptr_ok;
  logic mode_ok;

  always_comb begin
    dec         = '0;
    dec.psel    = PSEL_X;
    dec.mode    = AM_PLAIN;
    dec.store   = insn[9];
    dec.reg_idx = insn[8:4];
    ptr_ok      = 1'b0;
    mode_ok     = 1'b0;
    if (insn[15:10] == IND_PREFIX) begin
      case (insn[3:2])
        2'b11:   begin dec.psel = PSEL_X; ptr_ok = 1'b1; end
        2'b10:   begin dec.psel = PSEL_Y; ptr_ok = 1'b1; end
        2'b00:   begin dec.psel = PSEL_Z; ptr_ok = 1'b1; end
        default: ptr_ok = 1'b0;
      endcase
      case (insn[1:0])
        2'b00:   begin dec.mode = AM_PLAIN;   mode_ok = (insn[3:2] == 2'b11); end
        2'b01:   begin dec.mode = AM_POSTINC; mode_ok = 1'b1; end
        2'b10:   begin dec.mode = AM_PREDEC;  mode_ok = 1'b1; end
        default: mode_ok = 1'b0;
      endcase
      dec.hit = ptr_ok & mode_ok;
    end else if ((insn[15:12] & DISP_MASK) == DISP_PREFIX) begin
      dec.hit  = 1'b1;
      dec.mode = AM_DISP;
      dec.psel = insn[3] ? PSEL_Y : PSEL_Z;
      dec.disp = {insn[13], insn[11:10], insn[2:0]};
    end
  end
endmodule

// File: rtl/lsag_agen.sv
module lsag_agen
  import lsag_pkg::*;
#(
  parameter int AW = 16
) (
  input  lsag_dec_t      dec,
  input  logic [AW-1:0]  ptr_x,
  input  logic [AW-1:0]  ptr_y,
  input  logic [AW-1:0]  ptr_z,
  output logic [AW-1:0]  addr,
  output logic           wb_en,
  output logic [AW-1:0]  wb_val
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] base;
  logic [AW-1:0] plus_one;
  logic [AW-1:0] minus_one;
  logic [AW-1:0] plus_disp;

  always_comb begin
    case (dec.psel)
      PSEL_Y:  base = ptr_y;
      PSEL_Z:  base = ptr_z;
      default: base = ptr_x;
    endcase
  end

  assign plus_one  = base + ONE;
  assign minus_one = base - ONE;
  assign plus_disp = base + AW'(dec.disp);

  always_comb begin
    addr   = base;
    wb_en  = 1'b0;
    wb_val = plus_one;
    case (dec.mode)
      AM_POSTINC: begin addr = base;      wb_en = 1'b1; wb_val = plus_one;  end
      AM_PREDEC:  begin addr = minus_one; wb_en = 1'b1; wb_val = minus_one; end
      AM_DISP:    begin addr = plus_disp; end
      default:    begin addr = base; end
    endcase
  end
endmodule

// File: rtl/lsag_bound.sv
module lsag_bound #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  input  logic [AW:0]   mem_size,
  output logic          oob
);
  assign oob = ({1'b0, addr} >= mem_size);
endmodule

// File: rtl/ptr_ldst_agen.sv
module ptr_ldst_agen
  import lsag_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid_i,
  input  logic [INSN_W-1:0]    insn_i,
  input  logic [AW-1:0]        ptr_x_i,
  input  logic [AW-1:0]        ptr_y_i,
  input  logic [AW-1:0]        ptr_z_i,
  input  logic [AW:0]          mem_size_i,
  output logic                 acc_o,
  output logic                 oob_o,
  output logic                 store_o,
  output logic [REG_IDX_W-1:0] reg_idx_o,
  output logic [1:0]           ptr_sel_o,
  output logic [AW-1:0]        addr_o,
  output logic                 wb_en_o,
  output logic [AW-1:0]        wb_ptr_o
);
  lsag_dec_t     dec;
  logic [AW-1:0] addr_c;
  logic          wb_en_c;
  logic [AW-1:0] wb_val_c;
  logic          oob_c;
  logic          take;

  lsag_decode u_dec (.insn(insn_i), .dec(dec));

  lsag_agen #(.AW(AW)) u_agen (
    .dec(dec), .ptr_x(ptr_x_i), .ptr_y(ptr_y_i), .ptr_z(ptr_z_i),
    .addr(addr_c), .wb_en(wb_en_c), .wb_val(wb_val_c)
  );

  lsag_bound #(.AW(AW)) u_bound (
    .addr(addr_c), .mem_size(mem_size_i), .oob(oob_c)
  );

  assign take = in_valid_i & dec.hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_o     <= 1'b0;
      oob_o     <= 1'b0;
      store_o   <= 1'b0;
      reg_idx_o <= '0;
      ptr_sel_o <= '0;
      addr_o    <= '0;
      wb_en_o   <= 1'b0;
      wb_ptr_o  <= '0;
    end else begin
      acc_o     <= take & ~oob_c;
      oob_o     <= take & oob_c;
      wb_en_o   <= take & ~oob_c & wb_en_c;
      store_o   <= dec.store;
      reg_idx_o <= dec.reg_idx;
      ptr_sel_o <= dec.psel;
      addr_o    <= addr_c;
      wb_ptr_o  <= wb_val_c;
    end
  end

  // Idle input cycle gives no strobe in the next cycle.
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(in_valid_i) |-> (!acc_o && !oob_o && !wb_en_o));

  // Access and bounds error are exclusive.
  assert_acc_oob_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(acc_o && oob_o));

  // Write-back only accompanies an in-bounds access.
  assert_wb_needs_acc_R8: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> acc_o);

  // Write-back is the address (pre-decrement) or the address plus one (post-increment).
  assert_wb_value_R5_R6: assert property (@(posedge clk) disable iff (rst)
    wb_en_o |-> ((wb_ptr_o == addr_o) || (wb_ptr_o == addr_o + AW'(1))));

  // Accepted address lies below the memory size sampled with it.
  assert_in_bounds_R8: assert property (@(posedge clk) disable iff (rst)
    acc_o |-> ({1'b0, addr_o} < $past(mem_size_i)));

  // The pointer code 3 is never reported.
  assert_psel_legal_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_o || oob_o) |-> (ptr_sel_o != 2'd3));
endmodule

// File: tb/sim_ptr_ldst_agen.sv
module sim_ptr_ldst_agen;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid_i = 1'b0;
  logic [15:0]   insn_i = '0;
  logic [AW-1:0] ptr_x_i = '0, ptr_y_i = '0, ptr_z_i = '0;
  logic [AW:0]   mem_size_i = 17'h10000;
  logic          acc_o, oob_o, store_o, wb_en_o;
  logic [4:0]    reg_idx_o;
  logic [1:0]    ptr_sel_o;
  logic [AW-1:0] addr_o, wb_ptr_o;

  always #2 clk = ~clk;

  ptr_ldst_agen #(.AW(AW)) u0 (
    .clk(clk), .rst(rst), .in_valid_i(in_valid_i), .insn_i(insn_i),
    .ptr_x_i(ptr_x_i), .ptr_y_i(ptr_y_i), .ptr_z_i(ptr_z_i),
    .mem_size_i(mem_size_i), .acc_o(acc_o), .oob_o(oob_o),
    .store_o(store_o), .reg_idx_o(reg_idx_o), .ptr_sel_o(ptr_sel_o),
    .addr_o(addr_o), .wb_en_o(wb_en_o), .wb_ptr_o(wb_ptr_o)
  );

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  bit         e_acc = 0, e_oob = 0, e_wb = 0, e_st = 0;
  bit [4:0]   e_reg = 0;
  bit [1:0]   e_sel = 0;
  bit [15:0]  e_addr = 0, e_wbv = 0;
  string      e_tag = "R9";

  function automatic bit [15:0] ind(bit st, bit [4:0] r, bit [1:0] pc, bit [1:0] md);
    return {6'b100100, st, r, pc, md};
  endfunction

  function automatic bit [15:0] dsp(bit st, bit [4:0] r, bit y, bit [5:0] q);
    return {2'b10, q[5], 1'b0, q[4:3], st, r, y, q[2:0]};
  endfunction

  task automatic chk1(string f, int got, int exp);
    if (got != exp) begin
      miscompares++;
      $display("FAIL %s %s: got %h expected %h", e_tag, f, got, exp);
    end
  endtask

  task automatic compare();
    vectors++;
    chk1("acc", acc_o, e_acc);
    chk1("oob", oob_o, e_oob);
    chk1("wb_en", wb_en_o, e_wb);
    if (e_acc || e_oob) begin
      chk1("store", store_o, e_st);
      chk1("reg", reg_idx_o, e_reg);
      chk1("ptr_sel", ptr_sel_o, e_sel);
      chk1("addr", addr_o, e_addr);
    end
    if (e_wb) chk1("wb_ptr", wb_ptr_o, e_wbv);
  endtask

  // Behavioural reference built from the requirements.
  task automatic model(bit v, bit [15:0] op, bit [15:0] px, bit [15:0] py,
                       bit [15:0] pz, bit [16:0] msz, string tag);
    bit hit = 0, dowb = 0;
    int p = 0, a = 0, w = 0, q = 0;
    int sel = 0;
    e_tag = tag;
    e_st  = op[9];
    e_reg = op[8:4];
    if (op[15:10] == 6'b100100) begin
      case (op[3:2])
        2'b11: sel = 0;
        2'b10: sel = 1;
        2'b00: sel = 2;
        default: sel = -1;
      endcase
      p = (sel == 0) ? px : (sel == 1) ? py : pz;
      if (sel >= 0) begin
        if (op[1:0] == 2'b00 && sel == 0) begin hit = 1; a = p; end
        else if (op[1:0] == 2'b01) begin hit = 1; a = p; w = (p + 1) % 65536; dowb = 1; end
        else if (op[1:0] == 2'b10) begin hit = 1; w = (p + 65535) % 65536; a = w; dowb = 1; end
      end
    end else if ((op[15:12] & 4'b1101) == 4'b1000) begin
      hit = 1;
      sel = op[3] ? 1 : 2;
      p   = op[3] ? py : pz;
      q   = op[13] * 32 + op[11:10] * 8 + op[2:0];
      a   = (p + q) % 65536;
    end
    e_sel  = sel[1:0];
    e_addr = a[15:0];
    e_wbv  = w[15:0];
    e_acc  = v && hit && (a < msz);
    e_oob  = v && hit && (a >= msz);
    e_wb   = e_acc && dowb;
  endtask

  task automatic apply(bit v, bit [15:0] op, bit [15:0] px, bit [15:0] py,
                       bit [15:0] pz, bit [16:0] msz, string tag);
    @(negedge clk);
    compare();
    model(v, op, px, py, pz, msz, tag);
    rst = 0;
    in_valid_i = v; insn_i = op;
    ptr_x_i = px; ptr_y_i = py; ptr_z_i = pz; mem_size_i = msz;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  initial begin
    // R9: outputs zero while reset is held
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      e_tag = "R9";
      e_acc = 0; e_oob = 0; e_wb = 0;
      compare();
      chk1("addr_rst", addr_o, 0);
      chk1("wbptr_rst", wb_ptr_o, 0);
      chk1("reg_rst", reg_idx_o, 0);
    end
    e_tag = "R9";
    // R2 R4: X plain load and store
    apply(1, ind(0, 5'd3, 2'b11, 2'b00), 16'h0120, 16'h0200, 16'h0300, 17'h2000, "R4");
    apply(1, ind(1, 5'd31, 2'b11, 2'b00), 16'h1FFF, 16'h0, 16'h0, 17'h2000, "R2");
    // R5: post-increment on each pointer, with wrap
    apply(1, ind(0, 5'd7, 2'b11, 2'b01), 16'h0040, 16'h0, 16'h0, 17'h10000, "R5");
    apply(1, ind(1, 5'd8, 2'b10, 2'b01), 16'h0, 16'hFFFF, 16'h0, 17'h10000, "R5");
    apply(1, ind(0, 5'd9, 2'b00, 2'b01), 16'h0, 16'h0, 16'h1234, 17'h10000, "R5");
    // R6: pre-decrement, wrap from 0, then the same wrap out of bounds (R8)
    apply(1, ind(1, 5'd1, 2'b00, 2'b10), 16'h0, 16'h0, 16'h0, 17'h10000, "R6");
    apply(1, ind(0, 5'd2, 2'b10, 2'b10), 16'h0, 16'h0800, 16'h0, 17'h2000, "R6");
    apply(1, ind(0, 5'd2, 2'b11, 2'b10), 16'h0, 16'h0, 16'h0, 17'h2000, "R8");
    // R3: rejected codes
    apply(1, ind(0, 5'd4, 2'b11, 2'b11), 16'h10, 16'h10, 16'h10, 17'h2000, "R3");
    apply(1, ind(0, 5'd4, 2'b01, 2'b01), 16'h10, 16'h10, 16'h10, 17'h2000, "R3");
    apply(1, ind(0, 5'd4, 2'b10, 2'b00), 16'h10, 16'h10, 16'h10, 17'h2000, "R3");
    apply(1, ind(1, 5'd4, 2'b00, 2'b00), 16'h10, 16'h10, 16'h10, 17'h2000, "R3");
    // R7: displacement bit patterns on Y and Z
    apply(1, dsp(0, 5'd10, 1, 6'd63), 16'h0, 16'h0100, 16'h0, 17'h2000, "R7");
    apply(1, dsp(1, 5'd11, 0, 6'd32), 16'h0, 16'h0, 16'h0100, 17'h2000, "R7");
    apply(1, dsp(0, 5'd12, 1, 6'd24), 16'h0, 16'h0100, 16'h0, 17'h2000, "R7");
    apply(1, dsp(1, 5'd13, 0, 6'd7), 16'h0, 16'h0, 16'hFFFE, 17'h10000, "R7");
    apply(1, dsp(0, 5'd14, 0, 6'd0), 16'h0, 16'h0, 16'h0555, 17'h2000, "R7");
    // R8: boundary at mem_size-1 and mem_size
    apply(1, ind(0, 5'd5, 2'b11, 2'b00), 16'h1FFF, 16'h0, 16'h0, 17'h2000, "R8");
    apply(1, ind(0, 5'd5, 2'b11, 2'b00), 16'h2000, 16'h0, 16'h0, 17'h2000, "R8");
    apply(1, ind(0, 5'd5, 2'b11, 2'b01), 16'h2000, 16'h0, 16'h0, 17'h2000, "R8");
    apply(1, dsp(0, 5'd5, 1, 6'd1), 16'h0, 16'h1FFF, 16'h0, 17'h2000, "R8");
    // R1: valid low, unrelated opcode
    apply(0, ind(0, 5'd6, 2'b11, 2'b01), 16'h10, 16'h0, 16'h0, 17'h2000, "R1");
    apply(1, 16'h0000, 16'h10, 16'h0, 16'h0, 17'h2000, "R1");
    apply(1, 16'hFFFF, 16'h10, 16'h0, 16'h0, 17'h2000, "R1");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      bit [15:0] op;
      int k = $urandom_range(0, 3);
      if (k == 0)      op = ind($urandom, $urandom, $urandom, $urandom);
      else if (k == 1) op = dsp($urandom, $urandom, $urandom, $urandom);
      else if (k == 2) op = $urandom;
      else             op = ind($urandom, $urandom, 2'b11, $urandom_range(0, 2));
      apply($urandom_range(0, 7) != 0, op, $urandom, $urandom, $urandom,
            17'($urandom_range(0, 65536)), "R1");
    end
    apply(0, 16'h0, 16'h0, 16'h0, 16'h0, 17'h2000, "R1");
    apply(0, 16'h0, 16'h0, 16'h0, 16'h0, 17'h2000, "R1");
    finish_run();
  end
endmodule